// File: doc/BRIEF.md
# LUT-Based Configurable Logic Cell

This block is one programmable logic cell for a reconfigurable fabric. Two 4-input lookup tables (F and G) each take their own four inputs and turn them into one bit. An 8-entry combiner table (H) takes the F result, the G result and one more cell input. With the same signals driven on both table inputs, F, G and H together realise any 5-input function. Two storage flip-flops, each with a synchronous force-to-value control and a clock enable, can register the cell's two outputs. Either output can also bypass its flip-flop.

All table contents and option bits live in a 47-bit configuration chain. The chain is loaded serially while `cfg_en` is high. When the RAM option is set, the F and G tables also act as a 16-word by 2-bit writable memory. The F inputs address both tables, and reads work exactly like normal table lookups.

Top module: `lut_cell`

## Requirements
- R1: While `rst_n` is low, every configuration bit and both flip-flops are cleared, so both outputs read 0.
- R2: On each rising edge with `cfg_en` high, `cfg_din` enters chain bit 0 and every chain bit moves up one place. After 47 shifts, the first bit sent sits in bit 46. Chain layout: bits 46..31 are F entries 15..0; bits 30..15 are G entries 15..0; bits 14..7 are H entries 7..0; bit 6 is the RAM option; bit 5 is the Y force value; bit 4 is the X force value; bit 3 selects registered Y; bit 2 selects H for Y; bit 1 selects registered X; bit 0 selects H for X.
- R3: The F result is the F entry whose index is `f_in`. The G result is the G entry whose index is `g_in`, or `f_in` when the RAM option is set. This holds for all 16 input codes.
- R4: The H result is the H entry at index {`h_in`, G result, F result}, with `h_in` as the most significant bit. Over all 32 codes, this gives a 5-input function.
- R5: The X source is the H result when bit 0 is set and the F result otherwise. The Y source is the H result when bit 2 is set and the G result otherwise. When its registered bit is clear, an output shows its source combinationally.
- R6: When its registered bit is set, an output shows its flip-flop. On a rising edge the flip-flop loads its source if its enable (`ce_x`/`ce_y`) is high, and holds its value otherwise.
- R7: On a rising edge with `sr_x` (or `sr_y`) high, that flip-flop takes its configured force value, whatever its enable is doing.
- R8: With the RAM option set, `cfg_en` low and `ram_we` high, a rising edge writes `ram_d[0]` into F entry `f_in` and `ram_d[1]` into G entry `f_in`. The written data can be read back at once.
- R9: `ram_we` changes no table entry when the RAM option is clear or when `cfg_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_din | input | 1 | Serial configuration data |
| f_in | input | 4 | F table inputs; also the RAM address |
| g_in | input | 4 | G table inputs |
| h_in | input | 1 | Extra input of the H combiner |
| ce_x | input | 1 | Clock enable, X flip-flop |
| ce_y | input | 1 | Clock enable, Y flip-flop |
| sr_x | input | 1 | Force X flip-flop to its configured value |
| sr_y | input | 1 | Force Y flip-flop to its configured value |
| ram_we | input | 1 | RAM write enable |
| ram_d | input | 2 | RAM write data (bit 0 to F, bit 1 to G) |
| x_out | output | 1 | Cell output X |
| y_out | output | 1 | Cell output Y |

## Verification
The properties assume that the inputs are stable around the rising edge. They also assume that the configuration changes only through the chain or through RAM writes, so that a table lookup seen in one cycle reflects the contents written in the edge before.

The stimulus changes every input half a period away from the edge. It loads whole configuration words before it sweeps the table inputs. It also holds `ram_we` high during one full chain load, so that the overlap case of R9 stays within what the model predicts.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;
   // option bits at the bottom of the configuration chain, MSB first
   typedef struct packed {
      logic ram_mode;
      logic y_srval;
      logic x_srval;
      logic y_reg;
      logic y_use_h;
      logic x_reg;
      logic x_use_h;
   } cell_ctrl_t;

   localparam int CTRL_W = $bits(cell_ctrl_t);
endpackage

// File: rtl/lut_cell_lut.sv
module lut_cell_lut #(
   parameter int K        = 4,
   parameter bit MUX_TREE = 1'b1
)(
   input  logic [(1<<K)-1:0] tbl,
   input  logic [K-1:0]      sel,
   output logic              y
);
   localparam int N = 1 << K;

   generate
      if (MUX_TREE) begin : g_tree
         // heap-ordered 2:1 mux tree, leaves at N-1 .. 2N-2
         logic [2*N-2:0] node;
         assign node[2*N-2:N-1] = tbl;
         for (genvar i = 0; i < N-1; i++) begin : g_node
            localparam int DEPTH = $clog2(i+2) - 1;
            assign node[i] = sel[K-1-DEPTH] ? node[2*i+2] : node[2*i+1];
         end
         assign y = node[0];
      end else begin : g_index
         assign y = tbl[sel];
      end
   endgenerate
endmodule

// File: rtl/lut_cell_store.sv
module lut_cell_store import lut_cell_pkg::*; #(
   parameter int FG_K = 4,
   parameter int H_K  = 3
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_en,
   input  logic                 cfg_din,
   input  logic                 wr_en,
   input  logic [FG_K-1:0]      wr_addr,
   input  logic [1:0]           wr_data,
   output logic [(1<<FG_K)-1:0] f_tbl,
   output logic [(1<<FG_K)-1:0] g_tbl,
   output logic [(1<<H_K)-1:0]  h_tbl,
   output cell_ctrl_t           ctrl
);
   localparam int FG_N = 1 << FG_K;
   localparam int H_N  = 1 << H_K;
   localparam int H_LO = CTRL_W;
   localparam int G_LO = H_LO + H_N;
   localparam int F_LO = G_LO + FG_N;
   localparam int CW   = F_LO + FG_N;

   logic [CW-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else if (cfg_en) begin
         chain <= {chain[CW-2:0], cfg_din};
      end else if (wr_en) begin
         chain[F_LO + int'(wr_addr)] <= wr_data[0];
         chain[G_LO + int'(wr_addr)] <= wr_data[1];
      end
   end

   assign f_tbl = chain[F_LO +: FG_N];
   assign g_tbl = chain[G_LO +: FG_N];
   assign h_tbl = chain[H_LO +: H_N];
   assign ctrl  = cell_ctrl_t'(chain[CTRL_W-1:0]);
endmodule

// File: rtl/lut_cell_ff.sv
module lut_cell_ff (
   input  logic clk,
   input  logic rst_n,
   input  logic sr,
   input  logic srval,
   input  logic ce,
   input  logic d,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (sr)  q <= srval;
      else if (ce)  q <= d;
   end
endmodule

// File: rtl/lut_cell.sv
module lut_cell import lut_cell_pkg::*; #(
   parameter int FG_K     = 4,
   parameter int H_K      = 3,
   parameter bit MUX_TREE = 1'b1
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_en,
   input  logic            cfg_din,
   input  logic [FG_K-1:0] f_in,
   input  logic [FG_K-1:0] g_in,
   input  logic            h_in,
   input  logic            ce_x,
   input  logic            ce_y,
   input  logic            sr_x,
   input  logic            sr_y,
   input  logic            ram_we,
   input  logic [1:0]      ram_d,
   output logic            x_out,
   output logic            y_out
);
   localparam int FG_N = 1 << FG_K;
   localparam int H_N  = 1 << H_K;

   generate
      if (FG_K < 1 || FG_K > 6) begin : g_bad_fg
         $error("lut_cell: FG_K must lie in 1..6");
      end
      if (H_K != 3) begin : g_bad_h
         $error("lut_cell: H_K must be 3 (F, G and one extra input)");
      end
   endgenerate

   logic [FG_N-1:0] f_tbl, g_tbl;
   logic [H_N-1:0]  h_tbl;
   cell_ctrl_t      ctrl;
   logic            wr_en;
   logic [FG_K-1:0] g_addr;
   logic            f_o, g_o, h_o;
   logic [1:0]      comb, ffq, sr_v, ce_v, srval_v, reg_v;

   assign wr_en  = ctrl.ram_mode & ram_we & ~cfg_en;
   assign g_addr = ctrl.ram_mode ? f_in : g_in;

   lut_cell_store #(.FG_K(FG_K), .H_K(H_K)) u_store (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
      .wr_en(wr_en), .wr_addr(f_in), .wr_data(ram_d),
      .f_tbl(f_tbl), .g_tbl(g_tbl), .h_tbl(h_tbl), .ctrl(ctrl)
   );

   lut_cell_lut #(.K(FG_K), .MUX_TREE(MUX_TREE)) u_f (
      .tbl(f_tbl), .sel(f_in), .y(f_o));
   lut_cell_lut #(.K(FG_K), .MUX_TREE(MUX_TREE)) u_g (
      .tbl(g_tbl), .sel(g_addr), .y(g_o));
   lut_cell_lut #(.K(H_K), .MUX_TREE(MUX_TREE)) u_h (
      .tbl(h_tbl), .sel({h_in, g_o, f_o}), .y(h_o));

   assign comb[0]    = ctrl.x_use_h ? h_o : f_o;
   assign comb[1]    = ctrl.y_use_h ? h_o : g_o;
   assign sr_v       = {sr_y, sr_x};
   assign ce_v       = {ce_y, ce_x};
   assign srval_v    = {ctrl.y_srval, ctrl.x_srval};
   assign reg_v      = {ctrl.y_reg, ctrl.x_reg};

   generate
      for (genvar i = 0; i < 2; i++) begin : g_ff
         lut_cell_ff u_ff (
            .clk(clk), .rst_n(rst_n), .sr(sr_v[i]), .srval(srval_v[i]),
            .ce(ce_v[i]), .d(comb[i]), .q(ffq[i]));
      end
   endgenerate

   assign x_out = reg_v[0] ? ffq[0] : comb[0];
   assign y_out = reg_v[1] ? ffq[1] : comb[1];
endmodule

// File: rtl/lut_cell_chk.sv
module lut_cell_chk import lut_cell_pkg::*; #(
   parameter int FG_K = 4
)(
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cfg_en,
   input logic                 cfg_din,
   input logic [FG_K-1:0]      f_in,
   input logic [FG_K-1:0]      g_in,
   input logic                 ram_we,
   input logic [1:0]           ram_d,
   input logic                 sr_x,
   input logic                 sr_y,
   input logic                 ce_x,
   input logic                 ce_y,
   input logic                 x_out,
   input logic                 y_out,
   input cell_ctrl_t           ctrl,
   input logic [(1<<FG_K)-1:0] f_tbl,
   input logic [(1<<FG_K)-1:0] g_tbl,
   input logic [1:0]           q
);
   // R2
   cfg_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_en |=> ctrl.x_use_h == $past(cfg_din));

   // R7
   srx_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sr_x |=> q[0] == $past(ctrl.x_srval));

   // R7
   sry_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sr_y |=> q[1] == $past(ctrl.y_srval));

   // R6
   x_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sr_x && !ce_x) |=> $stable(q[0]));

   // R6
   y_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sr_y && !ce_y) |=> $stable(q[1]));

   // R6
   x_reg_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.x_reg |-> x_out == q[0]);

   // R6
   y_reg_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.y_reg |-> y_out == q[1]);

   // R5
   x_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl.x_reg && !ctrl.x_use_h) |-> x_out == f_tbl[f_in]);

   // R5
   y_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl.y_reg && !ctrl.y_use_h && !ctrl.ram_mode) |-> y_out == g_tbl[g_in]);

   // R8
   ram_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.ram_mode && ram_we && !cfg_en) |=>
         (f_tbl[$past(f_in)] == $past(ram_d[0])) && (g_tbl[$past(f_in)] == $past(ram_d[1])));

   // R9
   ram_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl.ram_mode && !cfg_en) |=> $stable(f_tbl) && $stable(g_tbl));
endmodule

bind lut_cell lut_cell_chk #(.FG_K(FG_K)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
   .f_in(f_in), .g_in(g_in), .ram_we(ram_we), .ram_d(ram_d),
   .sr_x(sr_x), .sr_y(sr_y), .ce_x(ce_x), .ce_y(ce_y),
   .x_out(x_out), .y_out(y_out), .ctrl(ctrl),
   .f_tbl(f_tbl), .g_tbl(g_tbl), .q(ffq)
);

// File: tb/tb_lut_cell.sv
module tb_lut_cell;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_en = 1'b0, cfg_din = 1'b0;
   logic [3:0] f_in = '0, g_in = '0;
   logic       h_in = 1'b0;
   logic       ce_x = 1'b0, ce_y = 1'b0, sr_x = 1'b0, sr_y = 1'b0;
   logic       ram_we = 1'b0;
   logic [1:0] ram_d = '0;
   logic       x_out, y_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // behavioural model state: configuration word and two flip-flops
   logic [46:0] m_cfg = '0;
   logic        m_qx = 1'b0, m_qy = 1'b0;

   always #2 clk = ~clk; // 250 MHz

   lut_cell dut (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
      .f_in(f_in), .g_in(g_in), .h_in(h_in),
      .ce_x(ce_x), .ce_y(ce_y), .sr_x(sr_x), .sr_y(sr_y),
      .ram_we(ram_we), .ram_d(ram_d), .x_out(x_out), .y_out(y_out)
   );

   function automatic logic m_fval();
      return m_cfg[31 + int'(f_in)];
   endfunction

   function automatic logic m_gval();
      logic [3:0] a;
      a = m_cfg[6] ? f_in : g_in;
      return m_cfg[15 + int'(a)];
   endfunction

   function automatic logic m_hval();
      return m_cfg[7 + int'({h_in, m_gval(), m_fval()})];
   endfunction

   function automatic logic m_xsrc();
      return m_cfg[0] ? m_hval() : m_fval();
   endfunction

   function automatic logic m_ysrc();
      return m_cfg[2] ? m_hval() : m_gval();
   endfunction

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   // inputs are already set (just after a falling edge); compare, then edge
   task automatic cyc(input string tag);
      logic xs, ys;
      #1;
      check({tag, " x"}, x_out, m_cfg[1] ? m_qx : m_xsrc());
      check({tag, " y"}, y_out, m_cfg[3] ? m_qy : m_ysrc());
      xs = m_xsrc();
      ys = m_ysrc();
      @(posedge clk);
      if (rst_n) begin
         m_qx = sr_x ? m_cfg[4] : (ce_x ? xs : m_qx);
         m_qy = sr_y ? m_cfg[5] : (ce_y ? ys : m_qy);
         if (cfg_en) begin
            m_cfg = {m_cfg[45:0], cfg_din};
         end else if (m_cfg[6] && ram_we) begin
            m_cfg[31 + int'(f_in)] = ram_d[0];
            m_cfg[15 + int'(f_in)] = ram_d[1];
         end
      end
      @(negedge clk);
   endtask

   task automatic load(input logic [46:0] word, input string tag);
      for (int k = 46; k >= 0; k--) begin
         cfg_en  = 1'b1;
         cfg_din = word[k];
         f_in    = 4'(k);
         g_in    = 4'(k * 3);
         cyc(tag);
      end
      cfg_en = 1'b0;
   endtask

   initial begin
      @(negedge clk);
      // R1: outputs cleared under reset
      for (int i = 0; i < 3; i++) begin
         f_in = 4'(i * 5);
         cyc("R1");
      end
      rst_n = 1'b1;

      // R2 chain load, then R4/R5: X takes H over 32 codes, Y takes G
      load({16'hA5C3, 16'h6E19, 8'hD4, 7'b0000001}, "R2");
      for (int i = 0; i < 32; i++) begin
         f_in = 4'(i);
         g_in = 4'(i);
         h_in = i[4];
         cyc("R4 R5");
      end

      // R3: both tables combinational, independent inputs
      load({16'h3C96, 16'hF00D, 8'h17, 7'b0000000}, "R2");
      for (int i = 0; i < 16; i++) begin
         f_in = 4'(i);
         g_in = ~4'(i);
         cyc("R3");
      end

      // R6 R7: registered outputs, random enables and force controls
      load({16'h8421, 16'h7BDE, 8'h69, 7'b0011110}, "R2");
      for (int i = 0; i < 200; i++) begin
         f_in = 4'($urandom_range(0, 15));
         g_in = 4'($urandom_range(0, 15));
         h_in = 1'($urandom_range(0, 1));
         ce_x = 1'($urandom_range(0, 1));
         ce_y = 1'($urandom_range(0, 1));
         sr_x = ($urandom_range(0, 3) == 0);
         sr_y = ($urandom_range(0, 3) == 0);
         cyc("R6 R7");
      end
      sr_x = 1'b1; sr_y = 1'b1; ce_x = 1'b1; ce_y = 1'b1;
      cyc("R7");
      sr_x = 1'b0; sr_y = 1'b0;
      cyc("R7");
      ce_x = 1'b0; ce_y = 1'b0;

      // R8: RAM mode write then read back, G addressed by f_in
      load({16'h0000, 16'hFFFF, 8'h00, 7'b1000000}, "R2");
      for (int i = 0; i < 16; i++) begin
         f_in   = 4'(i);
         g_in   = 4'(15 - i);
         ram_d  = 2'(i * 7 + 1);
         ram_we = 1'b1;
         cyc("R8");
      end
      ram_we = 1'b0;
      for (int i = 0; i < 16; i++) begin
         f_in = 4'(i);
         g_in = 4'(i + 9);
         cyc("R8");
      end

      // R9: write enable held high during a chain load
      ram_we = 1'b1;
      ram_d  = 2'b11;
      load({16'h1248, 16'hC0DE, 8'hF0, 7'b0000000}, "R9");
      // R9: writes with the RAM option clear
      for (int i = 0; i < 16; i++) begin
         f_in  = 4'(i);
         g_in  = 4'(i);
         ram_d = 2'(~i);
         cyc("R9");
      end
      ram_we = 1'b0;
      for (int i = 0; i < 16; i++) begin
         f_in = 4'(i);
         g_in = 4'(i);
         cyc("R9");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule